// File: doc/BRIEF.md
# Read Burst Truncation Command Scheduler

This controller-side sequencer turns read and write requests into a memory command stream. A read request carries a bank, a column, an auto-precharge flag, a count of wanted data pairs and an ending style. The block puts the READ on the command bus. It then makes sure the burst is cut after exactly the wanted number of pairs. It does this either by placing a BURST TERMINATE or a same-bank PRECHARGE itself, or by holding the next READ until the correct cycle.

Write requests are held until the last read burst has drained, and requests that break the truncation rules are rejected with an error pulse. The command bus has one slot per clock. An empty slot carries NOP.

Requests use a valid/ready handshake. `req_ready` is combinational in the current cycle. An accepted request shows up on the registered command bus in the next cycle.

Top module: `rd_trunc_sched`

## Requirements
- R1: After reset the command bus carries NOP (code 0), the error flag is low, and `req_ready` is high because no burst is in flight.
- R2: An accepted legal read request puts READ (code 1) on the bus in the following cycle, with the request's bank, column and auto-precharge flag.
- R3: Ending style 2 (terminate) puts BURST TERMINATE (code 3) on the bus exactly x cycles after the READ, where x is the wanted pair count.
- R4: Ending style 3 (precharge) puts PRECHARGE (code 4) on the bus exactly x cycles after the READ, addressed to the READ's bank.
- R5: Ending style 1 (chain) holds any following READ until it lands exactly x cycles after the first READ. When x is 1, that is the cycle right after it.
- R6: Ending style 0 (full burst) without auto precharge accepts a following READ in any cycle, so that READ reaches the bus on any later clock.
- R7: A WRITE (code 2) reaches the bus no earlier than E+CL cycles after the last READ. E is x for styles 2 and 3, and BL/2 for styles 0 and 1.
- R8: A read request is rejected if its pair count is 0 or above BL/2, or if it sets auto precharge with any style other than 0. A rejected request is consumed, raises `err` for one cycle in the next cycle, and issues no command.
- R9: Any cycle with nothing to issue carries NOP (code 0) on the bus.
- R10: After a full-burst READ with auto precharge, a following READ is held until it lands at least BL/2 cycles after the first.
- R11: In the cycle where a terminating command is chosen, `req_ready` is low, so that command takes the bus slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_bank | input | 2 | Target bank |
| req_col | input | 10 | Starting column |
| req_ap | input | 1 | Auto precharge for this access |
| req_pairs | input | PW (3) | Wanted data pairs for a read |
| req_mode | input | 2 | Ending style: 0 full, 1 chain, 2 terminate, 3 precharge |
| cmd_code | output | 3 | Command: 0 NOP, 1 READ, 2 WRITE, 3 BURST TERMINATE, 4 PRECHARGE |
| cmd_bank | output | 2 | Command bank |
| cmd_col | output | 10 | Command column (0 for terminate and precharge) |
| cmd_ap | output | 1 | Command auto-precharge flag |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
`req_ready` is due in the same cycle as the request it answers. The command and `err` are due one clock after acceptance. A terminating command lands x clocks after its READ, and a write no earlier than E+CL clocks after it. The bench keeps an absolute cycle count and records the bus cycle of the last READ. From that record it predicts `req_ready` for the current cycle and the bus contents for the next cycle. It compares both at the falling edge, so each result is checked in the very cycle it is due. Every early or late command therefore shows up as a mismatch.

// File: rtl/rts_pkg.sv
package rts_pkg;

    localparam int BANK_W = 2;
    localparam int COL_W  = 10;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_READ  = 3'd1,
        CMD_WRITE = 3'd2,
        CMD_BST   = 3'd3,
        CMD_PRE   = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        END_FULL  = 2'd0,
        END_CHAIN = 2'd1,
        END_BST   = 2'd2,
        END_PRE   = 2'd3
    } end_e;

    typedef struct packed {
        cmd_e              code;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic              ap;
    } bus_t;

    // true when the scheduler itself issues the cutting command
    function automatic logic self_cut(end_e m);
        return (m == END_BST) || (m == END_PRE);
    endfunction

endpackage

// File: rtl/rts_check.sv
module rts_check
    import rts_pkg::*;
#(
    parameter int HALF = 4,
    parameter int PW   = 3
) (
    input  logic          is_write,
    input  logic          ap,
    input  end_e          mode,
    input  logic [PW-1:0] pairs,
    output logic          bad
);
    logic pairs_bad;
    logic ap_bad;

    always_comb begin
        pairs_bad = (pairs == '0) || (int'(pairs) > HALF);
        ap_bad    = ap && (mode != END_FULL);
        bad       = !is_write && (pairs_bad || ap_bad);
    end
endmodule

// File: rtl/rts_track.sv
module rts_track
    import rts_pkg::*;
#(
    parameter int HALF = 4,
    parameter int CL   = 3,
    parameter int PW   = 3,
    parameter int CW   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_go,
    input  logic [PW-1:0]     rd_pairs,
    input  end_e              rd_mode,
    input  logic              rd_ap,
    input  logic [BANK_W-1:0] rd_bank,
    output logic              fire,
    output bus_t              fire_cmd,
    output logic              read_ok,
    output logic              write_ok,
    output logic [CW-1:0]     cnt_o,
    output logic [PW-1:0]     x_o,
    output end_e              mode_o,
    output logic              ap_o,
    output logic [BANK_W-1:0] bank_o
);
    localparam int SAT = HALF + CL;

    logic [CW-1:0]     cnt;
    logic [PW-1:0]     x;
    end_e              mode;
    logic              ap;
    logic              cut_done;
    logic [BANK_W-1:0] bank;
    int                eff;

    always_comb begin
        eff      = self_cut(mode) ? int'(x) : HALF;
        fire     = self_cut(mode) && !cut_done && (int'(cnt) == int'(x) - 1);
        write_ok = int'(cnt) >= eff + CL - 1;
        unique case (mode)
            END_FULL:  read_ok = !ap || (int'(cnt) >= HALF - 1);
            END_CHAIN: read_ok = int'(cnt) >= int'(x) - 1;
            default:   read_ok = cut_done;
        endcase
        fire_cmd.code = (mode == END_PRE) ? CMD_PRE : CMD_BST;
        fire_cmd.bank = bank;
        fire_cmd.col  = '0;
        fire_cmd.ap   = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= CW'(SAT);
            x        <= PW'(HALF);
            mode     <= END_FULL;
            ap       <= 1'b0;
            cut_done <= 1'b1;
            bank     <= '0;
        end else if (rd_go) begin
            cnt      <= '0;
            x        <= rd_pairs;
            mode     <= rd_mode;
            ap       <= rd_ap;
            bank     <= rd_bank;
            cut_done <= !self_cut(rd_mode);
        end else begin
            if (int'(cnt) < SAT) cnt <= cnt + 1'b1;
            if (fire) cut_done <= 1'b1;
        end
    end

    assign cnt_o  = cnt;
    assign x_o    = x;
    assign mode_o = mode;
    assign ap_o   = ap;
    assign bank_o = bank;

    AST_CUT_ONCE: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire) else $error("cut fired twice");                // R3
endmodule

// File: rtl/rts_drive.sv
module rts_drive
    import rts_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  bus_t nxt,
    input  logic err_in,
    output bus_t bus_q,
    output logic err_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q.code <= CMD_NOP;
            bus_q.bank <= '0;
            bus_q.col  <= '0;
            bus_q.ap   <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            err_q <= err_in;
            if (load) begin
                bus_q <= nxt;
            end else begin
                bus_q.code <= CMD_NOP;
                bus_q.bank <= '0;
                bus_q.col  <= '0;
                bus_q.ap   <= 1'b0;
            end
        end
    end

    AST_IDLE_NOP: assert property (@(posedge clk) disable iff (rst)
        $past(!load) |-> bus_q.code == CMD_NOP) else $error("idle slot");  // R9
endmodule

// File: rtl/rd_trunc_sched.sv
module rd_trunc_sched
    import rts_pkg::*;
#(
    parameter  int BL   = 8,
    parameter  int CL   = 3,
    localparam int HALF = BL / 2,
    localparam int PW   = $clog2(HALF) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_ap,
    input  logic [PW-1:0]     req_pairs,
    input  logic [1:0]        req_mode,
    output logic [2:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_ap,
    output logic              err
);
    localparam int CW = $clog2(HALF + CL + 1);

    end_e              mode_in;
    logic              bad;
    logic              fire;
    bus_t              fire_cmd;
    logic              read_ok;
    logic              write_ok;
    logic              accept;
    logic              issue;
    logic              rd_go;
    bus_t              nxt;
    bus_t              bus_q;
    logic [CW-1:0]     trk_cnt;
    logic [PW-1:0]     trk_x;
    end_e              trk_mode;
    logic              trk_ap;
    logic [BANK_W-1:0] trk_bank;

    assign mode_in = end_e'(req_mode);

    rts_check #(.HALF(HALF), .PW(PW)) u_check (
        .is_write (req_write),
        .ap       (req_ap),
        .mode     (mode_in),
        .pairs    (req_pairs),
        .bad      (bad)
    );

    rts_track #(.HALF(HALF), .CL(CL), .PW(PW), .CW(CW)) u_track (
        .clk      (clk),
        .rst      (rst),
        .rd_go    (rd_go),
        .rd_pairs (req_pairs),
        .rd_mode  (mode_in),
        .rd_ap    (req_ap),
        .rd_bank  (req_bank),
        .fire     (fire),
        .fire_cmd (fire_cmd),
        .read_ok  (read_ok),
        .write_ok (write_ok),
        .cnt_o    (trk_cnt),
        .x_o      (trk_x),
        .mode_o   (trk_mode),
        .ap_o     (trk_ap),
        .bank_o   (trk_bank)
    );

    always_comb begin
        req_ready = !fire && (bad || (req_write ? write_ok : read_ok));
        accept    = req_valid && req_ready;
        issue     = accept && !bad;
        rd_go     = issue && !req_write;
        if (fire) begin
            nxt = fire_cmd;
        end else begin
            nxt.code = req_write ? CMD_WRITE : CMD_READ;
            nxt.bank = req_bank;
            nxt.col  = req_col;
            nxt.ap   = req_ap;
        end
    end

    rts_drive u_drive (
        .clk    (clk),
        .rst    (rst),
        .load   (fire || issue),
        .nxt    (nxt),
        .err_in (accept && bad),
        .bus_q  (bus_q),
        .err_q  (err)
    );

    assign cmd_code = bus_q.code;
    assign cmd_bank = bus_q.bank;
    assign cmd_col  = bus_q.col;
    assign cmd_ap   = bus_q.ap;

    AST_BST_AT_X: assert property (@(posedge clk) disable iff (rst)
        cmd_code == CMD_BST |-> int'(trk_cnt) == int'(trk_x)) else $error("bst timing");   // R3
    AST_PRE_SAME_BANK: assert property (@(posedge clk) disable iff (rst)
        cmd_code == CMD_PRE |-> (cmd_bank == trk_bank) && (int'(trk_cnt) == int'(trk_x)))
        else $error("pre timing or bank");                                                  // R4
    AST_WR_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
        cmd_code == CMD_WRITE |->
            int'(trk_cnt) >= (self_cut(trk_mode) ? int'(trk_x) : HALF) + CL)
        else $error("write too early");                                                     // R7
    AST_NO_AP_CUT: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == CMD_BST || cmd_code == CMD_PRE) |-> !trk_ap) else $error("ap cut");    // R8
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
        err |-> cmd_code == CMD_NOP) else $error("rejected request issued");                // R8
endmodule

// File: tb/tb_rd_trunc_sched.sv
module tb_rd_trunc_sched;
    import rts_pkg::*;

    localparam int BL   = 8;
    localparam int CL   = 3;
    localparam int HALF = BL / 2;
    localparam int PW   = $clog2(HALF) + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [BANK_W-1:0] req_bank  = '0;
    logic [COL_W-1:0]  req_col   = '0;
    logic              req_ap    = 1'b0;
    logic [PW-1:0]     req_pairs = '0;
    logic [1:0]        req_mode  = '0;
    logic              req_ready;
    logic [2:0]        cmd_code;
    logic [BANK_W-1:0] cmd_bank;
    logic [COL_W-1:0]  cmd_col;
    logic              cmd_ap;
    logic              err;

    rd_trunc_sched #(.BL(BL), .CL(CL)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_col(req_col),
        .req_ap(req_ap), .req_pairs(req_pairs), .req_mode(req_mode),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
        .cmd_ap(cmd_ap), .err(err)
    );

    int checks = 0;
    int errors = 0;
    bit run    = 1'b0;
    bit done   = 1'b0;

    // reference model state (absolute cycle numbers)
    int    cyc    = 0;
    int    t_rd   = -1000;
    int    m_x    = HALF;
    int    m_mode = 0;
    int    m_bank = 0;
    bit    m_ap   = 1'b0;
    bit    m_cut  = 1'b1;
    int    e_code = 0;
    int    e_bank = 0;
    int    e_col  = 0;
    bit    e_ap   = 1'b0;
    bit    e_err  = 1'b0;
    string e_tag  = "R1";

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s cycle %0d actual=%0d expected=%0d", tag, what, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin : model
        bit    cut, fire, wok, rok, bad, exp_rdy, acc;
        int    p, eff;
        string rtag;
        if (run && !done) begin
            chk(int'(cmd_code) == e_code, e_tag, "cmd_code", int'(cmd_code), e_code);
            if (e_code != 0) begin
                chk(int'(cmd_bank) == e_bank, e_tag, "cmd_bank", int'(cmd_bank), e_bank);
                chk(int'(cmd_col) == e_col, e_tag, "cmd_col", int'(cmd_col), e_col);
                chk(cmd_ap == e_ap, e_tag, "cmd_ap", int'(cmd_ap), int'(e_ap));
            end
            chk(err == e_err, (e_tag == "R1") ? "R1" : "R8", "err", int'(err), int'(e_err));

            p    = int'(req_pairs);
            bad  = !req_write && (p == 0 || p > HALF || (req_ap && req_mode != 2'd0));
            cut  = (m_mode == 2) || (m_mode == 3);
            fire = cut && !m_cut && (cyc + 1 == t_rd + m_x);
            eff  = cut ? m_x : HALF;
            wok  = (cyc + 1) >= t_rd + eff + CL;
            case (m_mode)
                0:       rok = !m_ap || ((cyc + 1) >= t_rd + HALF);
                1:       rok = (cyc + 1) >= t_rd + m_x;
                default: rok = m_cut;
            endcase
            exp_rdy = !fire && (bad || (req_write ? wok : rok));
            if (e_tag == "R1")      rtag = "R1";
            else if (fire)          rtag = "R11";
            else if (bad)           rtag = "R8";
            else if (req_write)     rtag = "R7";
            else if (m_mode == 1)   rtag = "R5";
            else if (m_mode == 0 && m_ap) rtag = "R10";
            else                    rtag = "R6";
            if (req_valid || e_tag == "R1")
                chk(req_ready == exp_rdy, rtag, "req_ready", int'(req_ready), int'(exp_rdy));

            acc    = req_valid && exp_rdy;
            e_err  = acc && bad;
            e_code = 0; e_bank = 0; e_col = 0; e_ap = 1'b0; e_tag = "R9";
            if (fire) begin
                e_code = (m_mode == 3) ? 4 : 3;
                e_bank = m_bank;
                e_tag  = (m_mode == 3) ? "R4" : "R3";
                m_cut  = 1'b1;
            end else if (acc && !bad) begin
                e_code = req_write ? 2 : 1;
                e_bank = int'(req_bank);
                e_col  = int'(req_col);
                e_ap   = req_ap;
                e_tag  = req_write ? "R7" : "R2";
                if (!req_write) begin
                    t_rd   = cyc + 1;
                    m_x    = p;
                    m_mode = int'(req_mode);
                    m_ap   = req_ap;
                    m_bank = int'(req_bank);
                    m_cut  = !(req_mode == 2'd2 || req_mode == 2'd3);
                end
            end
            cyc++;
        end
    end

    task automatic send(bit w, int bank, int col, bit ap, int mode, int pairs);
        req_valid = 1'b1;
        req_write = w;
        req_bank  = BANK_W'(bank);
        req_col   = COL_W'(col);
        req_ap    = ap;
        req_mode  = 2'(mode);
        req_pairs = PW'(pairs);
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        run = 1'b1;
        idle(2);
        // R2 R7: full burst then a write that must wait BL/2+CL
        send(1'b0, 1, 16, 1'b0, 0, 4);
        send(1'b1, 1, 32, 1'b0, 0, 1);
        idle(3);
        // R3 R7: terminate after 2 pairs, then write after x+CL
        send(1'b0, 2, 48, 1'b0, 2, 2);
        send(1'b1, 2, 64, 1'b0, 0, 1);
        idle(3);
        // R4 R11: precharge after 3 pairs, a read waits for the cut
        send(1'b0, 3, 80, 1'b0, 3, 3);
        send(1'b0, 0, 96, 1'b0, 0, 4);
        idle(6);
        // R5 R6: chain x=1, chain x=2, then back-to-back full reads
        send(1'b0, 1, 100, 1'b0, 1, 1);
        send(1'b0, 2, 104, 1'b0, 1, 2);
        send(1'b0, 3, 108, 1'b0, 0, 4);
        send(1'b0, 0, 112, 1'b0, 0, 4);
        idle(8);
        // R10: auto-precharge full burst holds the next read
        send(1'b0, 2, 120, 1'b1, 0, 4);
        send(1'b0, 1, 124, 1'b0, 0, 4);
        idle(8);
        // R8: rejects, then a legal write
        send(1'b0, 1, 200, 1'b1, 2, 2);
        send(1'b0, 1, 204, 1'b0, 0, 0);
        send(1'b0, 1, 208, 1'b0, 2, 5);
        send(1'b0, 1, 212, 1'b1, 1, 7);
        send(1'b1, 3, 216, 1'b1, 0, 0);
        idle(2);
        // R3 R7: terminate at the boundary x=BL/2, write right behind
        send(1'b0, 0, 300, 1'b0, 2, 4);
        send(1'b1, 0, 304, 1'b0, 0, 1);
        idle(10);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog cycle %0d actual=0 expected=1", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule